// File: doc/BRIEF.md
# Cascaded Programmable NOR-Plane Array

This block is a programmable logic array made of a chain of identical planes rather than a fixed AND-OR pair. Each plane owns a crosspoint matrix that picks, for every one of its output terms, which of its incoming lines are OR-ed together. A per-term polarity bit then either inverts that OR, giving a NOR, or passes it through as a buffered OR. The terms of one plane are the incoming lines of the next. Deep chains therefore give multi-level logic. A signal that must reach a later plane is carried there by a buffer term in each plane in between.

Primary inputs enter only at the first plane and are zero-extended to the plane width. Primary outputs are the low terms of the last active plane. A plane-count field chooses how many planes take part, and any planes after the last active one have no effect. Evaluation from `pla_in` to `pla_out` is purely combinational and holds no state.

The configuration arrives one bit per cycle on a valid/ready stream. `cfg_ready` is high while a load is in progress and low once it is complete. A source that sees `cfg_ready` low must hold its bit, and any bit offered while ready is low is discarded. A `cfg_start` pulse starts a fresh load. The parameters are `NUM_PLANES`, `TERMS` (lines and terms per plane), `N_IN` and `N_OUT`, where `N_IN` and `N_OUT` must not exceed `TERMS`.

Top module: `nor_cascade_pla`

## Requirements
- R1: After reset `cfg_done` is 0, `cfg_ready` is 1 and `pla_out` is 0.
- R2: A configuration bit is accepted on a rising edge where `cfg_valid` and `cfg_ready` are both 1. The k-th accepted bit (k from 0) sets chain position k. Positions 0..CW-1 hold the plane-count field, least significant bit first, with CW = max(1, clog2(NUM_PLANES)). Plane p starts at base B = CW + p*(TERMS*TERMS + TERMS). Within plane p, the crosspoint joining line i to term t is at position B + t*TERMS + i, and the polarity of term t is at position B + TERMS*TERMS + t. `cfg_done` goes to 1 on the edge that accepts the last bit, at position CW + NUM_PLANES*(TERMS*TERMS+TERMS) - 1.
- R3: While `cfg_done` is 1, `cfg_ready` is 0. Bits offered with `cfg_valid` are ignored and leave `pla_out` unchanged.
- R4: A `cfg_start` pulse clears `cfg_done` on the next edge and restarts the bit position at 0. It takes priority over a bit offered in the same cycle, which is discarded.
- R5: While `cfg_done` is 0, `pla_out` is 0 whatever `pla_in` is.
- R6: Each term outputs the OR of the lines whose crosspoint bit is 1. The result is inverted (NOR) when the polarity bit is 1 and passed unchanged (OR) when the polarity bit is 0.
- R7: A term with no crosspoint set outputs 1 in NOR mode and 0 in OR mode.
- R8: Line i of plane 0 is `pla_in[i]` for i < N_IN and 0 above that. Line i of plane p > 0 is term i of plane p-1.
- R9: A plane-count field value v makes min(v+1, NUM_PLANES) planes active. `pla_out[j]` is term j of the last active plane, and later planes have no effect.
- R10: `pla_out` is a combinational function of `pla_in` and the loaded configuration. It changes in the same cycle as `pla_in`, with no register in the path.
- R11: A NOR-based realisation of a 2-input XOR over three planes and a 3-bit ripple adder over nine planes yield a^b and a+b for every input combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Pulse that begins a new configuration load |
| cfg_valid | input | 1 | Configuration bit is offered |
| cfg_ready | output | 1 | Load in progress; an offered bit is taken |
| cfg_data | input | 1 | Configuration bit value |
| cfg_done | output | 1 | Full configuration loaded; array output enabled |
| pla_in | input | N_IN | Primary inputs to the first plane |
| pla_out | output | N_OUT | Primary outputs from the last active plane |

## Verification
The bench goes after the plane-count clamp: a field value above the physical plane count must fall back to the final plane, and a design that wrapped or indexed past the end would output garbage or zeros. It checks empty terms in both polarities, which a design that treated "no crosspoint" as don't-care would get wrong. It also checks deep chains that rely on pass-through buffers, where a single miswired plane link breaks the adder's upper sum bits. It also attacks the load handshake: bits pushed after completion must not shift the chain, and a restart must blank the outputs at once. A design that kept accepting bits would corrupt a configuration that was already correct.

// File: rtl/nca_pkg.sv
package nca_pkg;
  // Per-term output polarity as stored in the configuration chain.
  typedef enum logic {
    TERM_OR  = 1'b0,
    TERM_NOR = 1'b1
  } term_mode_e;

  // Width of the plane-count field for a given physical plane count.
  function automatic int count_width(input int planes);
    return (planes > 1) ? $clog2(planes) : 1;
  endfunction
endpackage

// File: rtl/nca_cfg_chain.sv
module nca_cfg_chain #(
  parameter int LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           valid,
  input  logic           data,
  output logic           ready,
  output logic           done,
  output logic [LEN-1:0] bits
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0]  pos_q;
  logic [LEN-1:0] shreg_q;
  logic           done_q;

  // New bits enter at the top; after LEN shifts the first bit sits at index 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      pos_q   <= '0;
      done_q  <= 1'b0;
    end else if (start) begin
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (valid && !done_q) begin
      if (LEN > 1) shreg_q <= {data, shreg_q[LEN-1:1]};
      else         shreg_q <= data;
      pos_q <= pos_q + 1'b1;
      if (pos_q == LAST) done_q <= 1'b1;
    end
  end

  assign ready = !done_q;
  assign done  = done_q;
  assign bits  = shreg_q;
endmodule

// File: rtl/nca_plane.sv
module nca_plane #(
  parameter int TERMS = 16
) (
  input  logic [TERMS-1:0]       lines,
  input  logic [TERMS*TERMS-1:0] xpoint,
  input  logic [TERMS-1:0]       mode,
  output logic [TERMS-1:0]       terms
);
  import nca_pkg::*;

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    logic wired_or;
    assign wired_or = |(lines & xpoint[t*TERMS +: TERMS]);
    assign terms[t] = (term_mode_e'(mode[t]) == TERM_NOR) ? !wired_or : wired_or;
  end
endmodule

// File: rtl/nca_out_sel.sv
module nca_out_sel #(
  parameter int NUM_PLANES = 4,
  parameter int TERMS      = 16,
  parameter int N_OUT      = 4,
  parameter int CW         = 2
) (
  input  logic [NUM_PLANES*TERMS-1:0] all_terms,
  input  logic [CW-1:0]               plane_count,
  input  logic                        enable,
  output logic [N_OUT-1:0]            out
);
  int last_idx;

  always_comb begin
    last_idx = int'(plane_count);
    if (last_idx > NUM_PLANES - 1) last_idx = NUM_PLANES - 1;
    out = '0;
    for (int p = 0; p < NUM_PLANES; p++) begin
      if (enable && (p == last_idx)) out = all_terms[p*TERMS +: N_OUT];
    end
  end
endmodule

// File: rtl/nor_cascade_pla.sv
module nor_cascade_pla #(
  parameter int NUM_PLANES = 10,
  parameter int TERMS      = 16,
  parameter int N_IN       = 6,
  parameter int N_OUT      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_start,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic             cfg_data,
  output logic             cfg_done,
  input  logic [N_IN-1:0]  pla_in,
  output logic [N_OUT-1:0] pla_out
);
  import nca_pkg::*;

  localparam int CW         = count_width(NUM_PLANES);
  localparam int XP_BITS    = TERMS * TERMS;
  localparam int PLANE_BITS = XP_BITS + TERMS;
  localparam int CHAIN_LEN  = CW + NUM_PLANES * PLANE_BITS;

  logic [CHAIN_LEN-1:0]        cfg_bits;
  logic [NUM_PLANES*TERMS-1:0] term_bus;
  logic [NUM_PLANES*TERMS-1:0] line_bus;

  nca_cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cfg_start),
    .valid (cfg_valid),
    .data  (cfg_data),
    .ready (cfg_ready),
    .done  (cfg_done),
    .bits  (cfg_bits)
  );

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    localparam int BASE = CW + p * PLANE_BITS;
    if (p == 0) begin : g_first
      assign line_bus[0 +: TERMS] = TERMS'(pla_in);
    end else begin : g_link
      assign line_bus[p*TERMS +: TERMS] = term_bus[(p-1)*TERMS +: TERMS];
    end
    nca_plane #(.TERMS(TERMS)) u_plane (
      .lines  (line_bus[p*TERMS +: TERMS]),
      .xpoint (cfg_bits[BASE +: XP_BITS]),
      .mode   (cfg_bits[BASE + XP_BITS +: TERMS]),
      .terms  (term_bus[p*TERMS +: TERMS])
    );
  end

  nca_out_sel #(
    .NUM_PLANES (NUM_PLANES),
    .TERMS      (TERMS),
    .N_OUT      (N_OUT),
    .CW         (CW)
  ) u_sel (
    .all_terms   (term_bus),
    .plane_count (cfg_bits[CW-1:0]),
    .enable      (cfg_done),
    .out         (pla_out)
  );
endmodule

// File: rtl/nca_checker.sv
module nca_checker #(
  parameter int N_IN  = 6,
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_start,
  input logic             cfg_valid,
  input logic             cfg_ready,
  input logic             cfg_done,
  input logic [N_IN-1:0]  pla_in,
  input logic [N_OUT-1:0] pla_out
);
  // R5: outputs blanked while the configuration is incomplete
  a_r5_out_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> (pla_out == '0));

  // R3: a finished load stays finished until a restart
  a_r3_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !cfg_start) |=> cfg_done);

  // R3: no bit is taken after completion
  a_r3_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !cfg_ready);

  // R4: restart clears completion on the next edge
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |=> !cfg_done);

  // R2: completion only follows an accepted bit
  a_r2_done_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> ($past(cfg_valid) && $past(cfg_ready) && !$past(cfg_start)));

  // R10: with a frozen configuration the output depends only on the input
  a_r10_no_state: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && $past(cfg_done) && $stable(pla_in)) |-> $stable(pla_out));
endmodule

bind nor_cascade_pla nca_checker #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_start (cfg_start),
  .cfg_valid (cfg_valid),
  .cfg_ready (cfg_ready),
  .cfg_done  (cfg_done),
  .pla_in    (pla_in),
  .pla_out   (pla_out)
);

// File: tb/sim_nor_cascade_pla.sv
`timescale 1ns/1ps
module sim_nor_cascade_pla;
  localparam int NP    = 10;
  localparam int T     = 16;
  localparam int NI    = 6;
  localparam int NO    = 4;
  localparam int CW    = 4;
  localparam int PB    = T*T + T;
  localparam int CHAIN = CW + NP*PB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_start = 1'b0, cfg_valid = 1'b0, cfg_data = 1'b0;
  logic cfg_ready, cfg_done;
  logic [NI-1:0] pla_in = '0;
  logic [NO-1:0] pla_out;

  int compared = 0;
  int mismatched = 0;
  string phase = "R1";

  logic [CHAIN-1:0] cfg;
  logic [CHAIN-1:0] m_bits;
  int m_cnt;
  bit m_done;

  always #10 clk = ~clk;

  nor_cascade_pla #(.NUM_PLANES(NP), .TERMS(T), .N_IN(NI), .N_OUT(NO)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_data(cfg_data), .cfg_done(cfg_done),
    .pla_in(pla_in), .pla_out(pla_out)
  );

  // Behavioural model of the loader: bits stored by their arrival index.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  <= 0;
      m_done <= 1'b0;
      m_bits <= '0;
    end else if (cfg_start) begin
      m_cnt  <= 0;
      m_done <= 1'b0;
    end else if (cfg_valid && !m_done) begin
      m_bits[m_cnt] <= cfg_data;
      m_cnt <= m_cnt + 1;
      if (m_cnt == CHAIN-1) m_done <= 1'b1;
    end
  end

  function automatic logic [NO-1:0] ref_eval(input logic [NI-1:0] x);
    logic [T-1:0] ln, nx;
    int v, act;
    ln = '0;
    for (int i = 0; i < NI; i++) ln[i] = x[i];
    v = 0;
    for (int b = 0; b < CW; b++) v += int'(m_bits[b]) << b;
    act = (v + 1 > NP) ? NP : v + 1;
    for (int p = 0; p < act; p++) begin
      for (int t = 0; t < T; t++) begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < T; i++)
          if (m_bits[CW + p*PB + t*T + i] && ln[i]) acc = 1'b1;
        nx[t] = m_bits[CW + p*PB + T*T + t] ? !acc : acc;
      end
      ln = nx;
    end
    return ln[NO-1:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, sampled mid high phase.
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      check({phase, " out"}, 32'(pla_out), 32'(m_done ? ref_eval(pla_in) : '0));
      check({phase, " ready"}, 32'(cfg_ready), 32'(!m_done));
      check({phase, " done"}, 32'(cfg_done), 32'(m_done));
    end
  end

  task automatic xp(input int p, input int t, input int i);
    cfg[CW + p*PB + t*T + i] = 1'b1;
  endtask
  task automatic inv(input int p, input int t);
    cfg[CW + p*PB + T*T + t] = 1'b1;
  endtask
  task automatic set_count(input int v);
    for (int b = 0; b < CW; b++) cfg[b] = v[b];
  endtask

  task automatic push_cfg();
    for (int k = 0; k < CHAIN; k++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_data  = cfg[k];
      pla_in    = NI'(k + 5);
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    check("R4 done cleared", 32'(cfg_done), 32'd0);
    check("R4 out blank", 32'(pla_out), 32'd0);
  endtask

  // One ripple stage spread over three planes: complement/buffer, minterms, OR.
  task automatic stage(input int pa, input int x, input int y, input int z,
                       input int n, input int ps[4]);
    int lx, ly, lz;
    inv(pa, 0); xp(pa, 0, x);
    inv(pa, 1); xp(pa, 1, y);
    inv(pa, 2); xp(pa, 2, z);
    xp(pa, 3, x); xp(pa, 4, y); xp(pa, 5, z);
    for (int k = 0; k < n; k++) xp(pa, 6+k, ps[k]);
    for (int m = 0; m < 8; m++) begin
      lx = m[2] ? 0 : 3;
      ly = m[1] ? 1 : 4;
      lz = m[0] ? 2 : 5;
      inv(pa+1, m); xp(pa+1, m, lx); xp(pa+1, m, ly); xp(pa+1, m, lz);
    end
    for (int k = 0; k < n; k++) xp(pa+1, 8+k, 6+k);
    for (int k = 0; k < n; k++) xp(pa+2, k, 8+k);
    for (int m = 0; m < 8; m++) begin
      if (m[0] ^ m[1] ^ m[2]) xp(pa+2, n, m);
      if ((int'(m[0]) + int'(m[1]) + int'(m[2])) >= 2) xp(pa+2, n+1, m);
    end
  endtask

  task automatic random_cfg(input int cnt);
    cfg = '0;
    for (int k = CW; k < CHAIN; k++) cfg[k] = (($urandom % 7) == 0);
    set_count(cnt);
  endtask

  task automatic sweep(input string tag);
    phase = tag;
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      pla_in = NI'(v);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out", 32'(pla_out), 32'd0);
    check("R1 ready", 32'(cfg_ready), 32'd1);
    check("R1 done", 32'(cfg_done), 32'd0);
    rst_n = 1'b1;

    // XOR: complements and buffers, two product NORs, final OR.
    cfg = '0;
    inv(0,0); xp(0,0,0); inv(0,1); xp(0,1,1); xp(0,2,0); xp(0,3,1);
    inv(1,0); xp(1,0,0); xp(1,0,3); inv(1,1); xp(1,1,2); xp(1,1,1);
    xp(2,0,0); xp(2,0,1);
    set_count(2);
    phase = "R5 load";
    push_cfg();
    check("R2 done after full load", 32'(cfg_done), 32'd1);
    phase = "R6 R8 R10 xor";
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      pla_in = NI'(v);
      @(posedge clk); #5;
      check("R11 xor", 32'(pla_out[0]), 32'(v[0] ^ v[1]));
    end

    // Extra bits after completion must be ignored.
    phase = "R3 extra bits";
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_data  = 1'b1;
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    check("R3 ready low", 32'(cfg_ready), 32'd0);
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      pla_in = NI'(v);
      @(posedge clk); #5;
      check("R3 xor intact", 32'(pla_out[0]), 32'(v[0] ^ v[1]));
    end

    // 3-bit ripple adder over nine planes.
    restart();
    cfg = '0;
    stage(0, 0, 3, 15, 4, '{1, 2, 4, 5});
    stage(3, 0, 2, 5, 3, '{4, 1, 3, 0});
    stage(6, 1, 2, 4, 2, '{0, 3, 0, 0});
    set_count(8);
    phase = "R5 load adder";
    push_cfg();
    phase = "R8 R9 adder";
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      pla_in = NI'(v);
      @(posedge clk); #5;
      check("R11 adder", 32'(pla_out), 32'((v & 7) + ((v >> 3) & 7)));
    end

    // Empty terms in both polarities, single plane active.
    restart();
    cfg = '0;
    inv(0, 0);
    set_count(0);
    phase = "R5 load empty";
    push_cfg();
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      pla_in = NI'(v * 9);
      @(posedge clk); #5;
      check("R7 empty NOR and OR", 32'(pla_out), 32'd1);
    end

    // Plane count above the physical count, and a short chain.
    restart();
    random_cfg(15);
    phase = "R5 load clamp";
    push_cfg();
    sweep("R9 clamp");
    restart();
    random_cfg(2);
    phase = "R5 load short";
    push_cfg();
    sweep("R9 R6 short");

    // Restart blanks outputs while the new load runs.
    restart();
    phase = "R4 R5 after restart";
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_data  = 1'b1;
      pla_in    = NI'(k);
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    check("R4 still loading", 32'(cfg_ready), 32'd1);
    @(negedge clk);
    finish_run();
  end
endmodule